// File: doc/BRIEF.md
# Double-to-Single Floating-Point Narrowing Converter

This block converts one binary64 floating-point operand into a binary32 result, together with the four exception flags invalid, overflow, underflow and inexact. The source is sorted into zero, subnormal, normal, infinity, quiet NaN or signalling NaN. It uses the legacy NaN convention: a set fraction MSB marks a *signalling* NaN. Normal operands have their significand narrowed with a sticky shift. The exponent is then rebiased, denormalized when it falls below the destination range, rounded under one of four directed modes, and packed. The result and flags are registered once, so the converter has a fixed latency of one clock.

Source subnormals lie far below the smallest destination subnormal. They collapse to a signed zero or to the smallest destination subnormal, depending on the rounding direction. NaN payloads are carried over by keeping their upper fraction bits. When a quiet payload truncates to zero, the default NaN is used in its place. All four format widths are parameters, so the same logic serves smaller formats that meet the same ordering of ranges.

Top module: `fcvt_d2s`

## Requirements
- R1: `rnd_mode` selects 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward −infinity. A normal operand whose value lies in the destination normal range gives the correctly rounded result under that mode.
- R2: Any nonzero bit discarded while narrowing the significand sets `flg_inexact`, including bits below the guard and round positions.
- R3: If the rounded magnitude reaches the destination exponent all-ones, or the rebiased exponent exceeds the largest finite exponent, then `flg_overflow` and `flg_inexact` are set. The result is infinity for nearest-even, for +infinity mode with a positive sign, and for −infinity mode with a negative sign. Otherwise it is the largest finite value with the operand's sign.
- R4: A normal operand whose rebiased exponent is below 1 is tiny. It is shifted into destination subnormal form with sticky before rounding, and it may round up to the smallest normal. `flg_underflow` is set exactly when the operand is tiny and the result is inexact.
- R5: A source subnormal always sets `flg_underflow` and `flg_inexact`. The result is +smallest subnormal (fraction field 1) for a positive operand in mode 2, and −smallest subnormal for a negative operand in mode 3. In all other cases it is a zero of the operand's sign.
- R6: A source infinity or zero gives an infinity or zero of the same sign, with no flag set.
- R7: A signalling NaN (exponent all ones, fraction MSB set) sets `flg_invalid`. The result has the same sign, an all-ones exponent, and the top destination-fraction-width bits of the source fraction.
- R8: A quiet NaN (exponent all ones, fraction MSB clear, fraction nonzero) sets no flag. It gives the same sign, an all-ones exponent and the top source fraction bits. If those bits are all zero, the result is the default NaN instead: sign 0, exponent all ones, fraction MSB 0 and all other fraction bits 1 (0x7FBFFFFF at default widths).
- R9: While `rst_n` is low, the result and all flags read zero. Otherwise the outputs show the conversion of the operand and mode present at the previous rising clock edge.
- R10: When rounding carries out of the fraction, the exponent field increases by one and the fraction field becomes zero.
- R11: `flg_invalid` is raised only for a signalling NaN operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_bits | input | 1+SRC_EW+SRC_FW (64) | Source operand: sign, exponent, fraction |
| rnd_mode | input | 2 | Rounding direction |
| res_bits | output | 1+DST_EW+DST_FW (32) | Converted result |
| flg_invalid | output | 1 | Invalid operation |
| flg_overflow | output | 1 | Overflow |
| flg_underflow | output | 1 | Underflow |
| flg_inexact | output | 1 | Inexact |

## Verification
The bench builds the converter with a 4-bit source exponent and 7-bit source fraction, and a 3-bit destination exponent and 2-bit destination fraction. These widths keep the same range ordering as the default formats: every source subnormal still lies below the smallest destination subnormal, and three sticky bits are still dropped. At this size all 4096 operands can be applied under all four rounding modes. Every tie, every carry into the exponent, every overflow threshold, every tiny value and every NaN payload is therefore reached. The expected values come from a scaled-integer division model rather than from shift-and-pack logic.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  typedef enum logic [1:0] {
    RND_NE = 2'd0,
    RND_TZ = 2'd1,
    RND_UP = 2'd2,
    RND_DN = 2'd3
  } rnd_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } cls_e;

  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic nx;
  } fflags_t;

endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW-1:0] exp_in,
  input  logic [FW-1:0] frac_in,
  output cls_e          cls
);

  logic exp_max;
  logic exp_min;
  logic frac_nz;

  always_comb begin
    exp_max = &exp_in;
    exp_min = ~|exp_in;
    frac_nz = |frac_in;
    if (exp_max) begin
      if (!frac_nz)             cls = CLS_INF;
      else if (frac_in[FW-1])   cls = CLS_SNAN;  // legacy convention
      else                      cls = CLS_QNAN;
    end else if (exp_min) begin
      cls = frac_nz ? CLS_SUB : CLS_ZERO;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/fcvt_narrow.sv
module fcvt_narrow #(
  parameter int SRC_EW = 11,
  parameter int SRC_FW = 52,
  parameter int DST_EW = 8,
  parameter int DST_FW = 23
) (
  input  logic [SRC_EW-1:0] exp_in,
  input  logic [SRC_FW-1:0] frac_in,
  output logic [DST_FW+2:0] grs_sig,
  output logic [DST_EW-1:0] efield,
  output logic              tiny,
  output logic              huge
);

  localparam int SH        = SRC_FW - DST_FW - 3;
  localparam int W         = DST_FW + 4;
  localparam int XW        = SRC_EW + 2;
  localparam int SRC_BIAS  = (1 << (SRC_EW - 1)) - 1;
  localparam int DST_BIAS  = (1 << (DST_EW - 1)) - 1;
  localparam int DST_EMAX  = (1 << DST_EW) - 2;

  logic [SRC_FW:0]        sig;
  logic [W-1:0]           base;
  logic [W-1:0]           shifted;
  logic signed [XW-1:0]   te;
  logic [XW-1:0]          dsh;
  logic                   lost;
  logic                   lead_unused;
  int                     shamt;

  always_comb begin
    sig     = {1'b1, frac_in};
    base    = sig[SRC_FW -: W];
    base[0] = base[0] | (|sig[SH-1:0]);

    te   = $signed({2'b00, exp_in}) - $signed(XW'(SRC_BIAS - DST_BIAS));
    tiny = te[XW-1] || (te == '0);
    huge = !te[XW-1] && ($unsigned(te) > XW'(DST_EMAX));

    dsh   = XW'(1) - $unsigned(te);
    shamt = 0;
    if (tiny) shamt = (int'(dsh) > W) ? W : int'(dsh);

    shifted = base >> shamt;
    lost    = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < shamt) lost = lost | base[i];
    end
    shifted[0]  = shifted[0] | lost;
    lead_unused = shifted[W-1];
    grs_sig     = shifted[W-2:0];
    efield      = tiny ? '0 : te[DST_EW-1:0];
  end

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
#(
  parameter int DST_EW = 8,
  parameter int DST_FW = 23
) (
  input  logic                     sign,
  input  logic [DST_FW+2:0]        grs_sig,
  input  logic [DST_EW-1:0]        efield,
  input  logic                     tiny,
  input  logic                     huge,
  input  rnd_e                     mode,
  output logic [DST_EW+DST_FW:0]   res,
  output fflags_t                  flags
);

  localparam int PW = DST_EW + DST_FW;

  logic          lsb, grd, stk, nx, inc, ovf, to_inf;
  logic [PW-1:0] sum;

  always_comb begin
    lsb = grs_sig[3];
    grd = grs_sig[2];
    stk = |grs_sig[1:0];
    nx  = grd | stk;
    unique case (mode)
      RND_NE:  inc = grd & (stk | lsb);
      RND_TZ:  inc = 1'b0;
      RND_UP:  inc = !sign & nx;
      default: inc = sign & nx;
    endcase
    sum    = {efield, grs_sig[DST_FW+2:3]} + PW'(inc);
    ovf    = huge | (&sum[PW-1 -: DST_EW]);
    to_inf = (mode == RND_NE) || (mode == RND_UP && !sign) || (mode == RND_DN && sign);
    if (ovf)
      res = to_inf ? {sign, {DST_EW{1'b1}}, {DST_FW{1'b0}}}
                   : {sign, {(DST_EW-1){1'b1}}, 1'b0, {DST_FW{1'b1}}};
    else
      res = {sign, sum};
    flags.nv = 1'b0;
    flags.of = ovf;
    flags.uf = tiny & nx;
    flags.nx = nx | ovf;
  end

endmodule

// File: rtl/fcvt_d2s.sv
module fcvt_d2s
  import fcvt_pkg::*;
#(
  parameter int SRC_EW = 11,
  parameter int SRC_FW = 52,
  parameter int DST_EW = 8,
  parameter int DST_FW = 23,
  localparam int SW = 1 + SRC_EW + SRC_FW,
  localparam int DW = 1 + DST_EW + DST_FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] src_bits,
  input  logic [1:0]    rnd_mode,
  output logic [DW-1:0] res_bits,
  output logic          flg_invalid,
  output logic          flg_overflow,
  output logic          flg_underflow,
  output logic          flg_inexact
);

  localparam logic [DW-1:0] DEF_NAN =
    {1'b0, {DST_EW{1'b1}}, 1'b0, {(DST_FW-1){1'b1}}};

  logic              sign;
  logic [SRC_EW-1:0] sexp;
  logic [SRC_FW-1:0] sfrac;
  logic [DST_FW-1:0] pay;
  rnd_e              mode;
  cls_e              cls;
  logic [DST_FW+2:0] grs_sig;
  logic [DST_EW-1:0] efield;
  logic              tiny, huge, min_pick;
  logic [DW-1:0]     rnd_res, res_nxt, res_q;
  fflags_t           rnd_flags, flg_nxt, flg_q;

  assign sign  = src_bits[SW-1];
  assign sexp  = src_bits[SW-2 -: SRC_EW];
  assign sfrac = src_bits[SRC_FW-1:0];
  assign pay   = sfrac[SRC_FW-1 -: DST_FW];
  assign mode  = rnd_e'(rnd_mode);

  fcvt_classify #(.EW(SRC_EW), .FW(SRC_FW)) u_cls (
    .exp_in(sexp), .frac_in(sfrac), .cls(cls)
  );

  fcvt_narrow #(.SRC_EW(SRC_EW), .SRC_FW(SRC_FW), .DST_EW(DST_EW), .DST_FW(DST_FW)) u_nar (
    .exp_in(sexp), .frac_in(sfrac), .grs_sig(grs_sig),
    .efield(efield), .tiny(tiny), .huge(huge)
  );

  fcvt_round #(.DST_EW(DST_EW), .DST_FW(DST_FW)) u_rnd (
    .sign(sign), .grs_sig(grs_sig), .efield(efield), .tiny(tiny),
    .huge(huge), .mode(mode), .res(rnd_res), .flags(rnd_flags)
  );

  // next-state selection
  always_comb begin
    res_nxt  = rnd_res;
    flg_nxt  = rnd_flags;
    min_pick = (mode == RND_UP && !sign) || (mode == RND_DN && sign);
    unique case (cls)
      CLS_SNAN: begin
        res_nxt = {sign, {DST_EW{1'b1}}, pay};
        flg_nxt = '{nv: 1'b1, of: 1'b0, uf: 1'b0, nx: 1'b0};
      end
      CLS_QNAN: begin
        res_nxt = (pay == '0) ? DEF_NAN : {sign, {DST_EW{1'b1}}, pay};
        flg_nxt = '0;
      end
      CLS_INF: begin
        res_nxt = {sign, {DST_EW{1'b1}}, {DST_FW{1'b0}}};
        flg_nxt = '0;
      end
      CLS_ZERO: begin
        res_nxt = {sign, {(DW-1){1'b0}}};
        flg_nxt = '0;
      end
      CLS_SUB: begin
        res_nxt = {sign, {(DW-2){1'b0}}, min_pick};
        flg_nxt = '{nv: 1'b0, of: 1'b0, uf: 1'b1, nx: 1'b1};
      end
      default: ;
    endcase
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign res_bits      = res_q;
  assign flg_invalid   = flg_q.nv;
  assign flg_overflow  = flg_q.of;
  assign flg_underflow = flg_q.uf;
  assign flg_inexact   = flg_q.nx;

  AST_OVF_SETS_NX: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> flg_inexact);  // R3
  AST_UF_SETS_NX: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> flg_inexact);  // R4
  AST_SUB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_SUB) |=> (flg_underflow && flg_inexact && !flg_overflow && !flg_invalid));  // R5
  AST_INF_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_INF || cls == CLS_ZERO) |=>
      !(flg_invalid || flg_overflow || flg_underflow || flg_inexact));  // R6
  AST_NAN_STAYS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_QNAN || cls == CLS_SNAN) |=>
      ((&res_bits[DW-2 -: DST_EW]) && (res_bits[DST_FW-1:0] != '0)));  // R8
  AST_NV_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
    flg_invalid |-> ($past(cls) == CLS_SNAN));  // R11

endmodule

// File: tb/sim_fcvt_d2s.sv
`timescale 1ns/1ps
module sim_fcvt_d2s;

  localparam int SEW = 4;
  localparam int SFW = 7;
  localparam int DEW = 3;
  localparam int DFW = 2;
  localparam int SW  = 1 + SEW + SFW;
  localparam int DW  = 1 + DEW + DFW;
  localparam int SB  = (1 << (SEW - 1)) - 1;
  localparam int DB  = (1 << (DEW - 1)) - 1;
  localparam int K   = SB + SFW - 1;   // scale: operand * 2^K is an integer

  logic          clk;
  logic          rst_n;
  logic [SW-1:0] src;
  logic [1:0]    md;
  logic [DW-1:0] res;
  logic          f_nv, f_of, f_uf, f_nx;
  int            checks;
  int            fails;
  bit            done;

  fcvt_d2s #(.SRC_EW(SEW), .SRC_FW(SFW), .DST_EW(DEW), .DST_FW(DFW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_bits(src), .rnd_mode(md), .res_bits(res),
    .flg_invalid(f_nv), .flg_overflow(f_of), .flg_underflow(f_uf), .flg_inexact(f_nx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // arithmetic reference: flags ordered {invalid, overflow, underflow, inexact}
  function automatic void ref_model(input logic [SW-1:0] x, input int mode,
                                    output logic [DW-1:0] r, output logic [3:0] fl,
                                    output string tag);
    logic           s;
    logic [SEW-1:0] e;
    logic [SFW-1:0] f;
    logic [DFW-1:0] p;
    longint         n, q, rem, half, packed_v;
    int             msb, ex, eeff, u;
    bit             up;
    s = x[SW-1];
    e = x[SW-2 -: SEW];
    f = x[SFW-1:0];
    p = f[SFW-1 -: DFW];
    fl = 4'b0000;
    if (&e) begin
      if (f == '0) begin
        r = {s, {DEW{1'b1}}, {DFW{1'b0}}}; tag = "R6";
      end else if (f[SFW-1]) begin
        r = {s, {DEW{1'b1}}, p}; fl = 4'b1000; tag = "R7";
      end else begin
        r = (p == '0) ? {1'b0, {DEW{1'b1}}, 1'b0, {(DFW-1){1'b1}}} : {s, {DEW{1'b1}}, p};
        tag = "R8";
      end
    end else if (e == '0) begin
      if (f == '0) begin
        r = {s, {(DW-1){1'b0}}}; tag = "R6";
      end else begin
        fl = 4'b0011; tag = "R5";
        r = ((mode == 2 && !s) || (mode == 3 && s)) ? {s, {(DW-2){1'b0}}, 1'b1}
                                                    : {s, {(DW-1){1'b0}}};
      end
    end else begin
      n = longint'({1'b1, f}) << (int'(e) - 1);
      msb = 0;
      for (int i = 0; i < 62; i++) if (((n >> i) & 1) != 0) msb = i;
      ex   = msb - K + DB;
      eeff = (ex < 1) ? 1 : ex;
      u    = eeff - DB - DFW + K;
      q    = n >> u;
      rem  = n & ((longint'(1) << u) - 1);
      half = longint'(1) << (u - 1);
      case (mode)
        0:       up = (rem > half) || (rem == half && q[0]);
        1:       up = 1'b0;
        2:       up = !s && rem != 0;
        default: up = s && rem != 0;
      endcase
      q = q + (up ? 1 : 0);
      packed_v = (ex >= 1) ? ((longint'(ex - 1) << DFW) + q) : q;
      if (packed_v >= (longint'((1 << DEW) - 1) << DFW)) begin
        fl = 4'b0101; tag = "R3";
        if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s))
          r = {s, {DEW{1'b1}}, {DFW{1'b0}}};
        else
          r = {s, {(DEW-1){1'b1}}, 1'b0, {DFW{1'b1}}};
      end else begin
        r = {s, packed_v[DW-2:0]};
        fl[0] = (rem != 0);
        fl[1] = (ex < 1) && (rem != 0);
        if (ex < 1)                          tag = "R4";
        else if ((packed_v >> DFW) != ex)    tag = "R10";
        else if (rem != 0)                   tag = "R1 R2";
        else                                 tag = "R1";
      end
    end
  endfunction

  task automatic check_vec(input logic [SW-1:0] x, input int mode);
    logic [DW-1:0] er;
    logic [3:0]    ef;
    logic [3:0]    af;
    string         tg;
    ref_model(x, mode, er, ef, tg);
    af = {f_nv, f_of, f_uf, f_nx};
    if (af[3] != ef[3]) tg = {tg, " R11"};
    checks++;
    if (res !== er || af !== ef) begin
      fails++;
      $display("FAIL %s x=%h mode=%0d got res=%h flags=%b exp res=%h flags=%b",
               tg, x, mode, res, af, er, ef);
    end
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; src = '1; md = 2'd3;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (res !== '0 || {f_nv, f_of, f_uf, f_nx} !== 4'b0) begin
      fails++;
      $display("FAIL R9 reset got res=%h flags=%b exp res=0 flags=0000",
               res, {f_nv, f_of, f_uf, f_nx});
    end
    rst_n = 1'b1;
    // R9: each result appears one edge after its operand is presented
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < (1 << SW); v++) begin
        @(negedge clk);
        src = SW'(v);
        md  = 2'(m);
        @(posedge clk);
        #1;
        check_vec(SW'(v), m);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule